// File: doc/BRIEF.md
# Branch and Jump Target Unit

This unit decides where control flow goes after a branch or jump in a 32-bit core whose control-flow instructions each carry one delay slot. In the issue cycle it receives the address of the control-flow instruction, a small operation code, the 16-bit displacement, the 26-bit jump index and two register operands. It then evaluates the branch condition and picks one of three target kinds: relative to the PC, absolute within the current 256 MB region, or read from a register. It also forms the return address for the linking variants.

The result is registered. For exactly one cycle after an accepted instruction the unit holds a pending state. During that cycle fetch delivers the delay-slot instruction, and the unit presents the redirect decision, the target and the link write. A register-indirect target that is not word aligned produces no redirect. Instead an exception pulse, carrying the bad address, appears in the cycle after the delay slot.

Top module: `bt_unit`

## Requirements
- R1: `op_i` encodes 0 none, 1 equal, 2 not-equal, 3 less-or-equal-zero, 4 greater-than-zero, 5 less-than-zero, 6 greater-or-equal-zero, 7 less-than-zero-and-link, 8 greater-or-equal-zero-and-link, 9 jump, 10 jump-and-link, 11 jump-register, 12 jump-register-and-link. All comparisons treat `rs_val_i` (and `rt_val_i` for codes 1 and 2) as signed 32-bit values. Codes 9 to 12 are always taken.
- R2: The target of a taken conditional branch is `pc_i + 8 + sext(off_i << 2)`, where the 18-bit shifted displacement is sign extended to 32 bits.
- R3: The target of codes 9 and 10 is `{(pc_i+4)[31:28], idx_i, 2'b00}`. The top four bits come from the delay-slot address, not from the branch address.
- R4: The target of codes 11 and 12 is `rs_val_i`. If bits [1:0] of that value are non-zero, no redirect is made. In that case `exc_o` pulses for one cycle, in the cycle after the pending cycle, with `exc_addr_o` equal to the bad value.
- R5: Codes 7, 8 and 10 write the link value `pc_i + 8` to register 31, whether or not the branch is taken.
- R6: Code 12 writes `pc_i + 8` to register `rd_i`. When `rd_i` is 0, no link write is made, but the jump still redirects.
- R7: An accepted instruction sets `pend_o` for exactly the next cycle. `redir_o`, `redir_pc_o`, `link_we_o`, `link_reg_o` and `link_data_o` are valid in that same cycle.
- R8: An issue made while `pend_o` is high has no effect, and neither does an issue with code 0 or 13 to 15. After either kind of issue, `pend_o`, `redir_o` and `link_we_o` are low in the next cycle.
- R9: After reset, `pend_o`, `redir_o`, `link_we_o` and `exc_o` are low.
- R10: Every redirect target has bits [1:0] equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | A control-flow instruction is presented this cycle |
| op_i | input | 4 | Operation code (R1) |
| pc_i | input | 32 | Address of the control-flow instruction |
| off_i | input | 16 | Signed word displacement |
| idx_i | input | 26 | Absolute jump word index |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| rd_i | input | 5 | Link destination for code 12 |
| pend_o | output | 1 | Redirect pending; the delay slot is being fetched |
| redir_o | output | 1 | Load `redir_pc_o` after the delay slot |
| redir_pc_o | output | 32 | Redirect target |
| link_we_o | output | 1 | Link register write enable |
| link_reg_o | output | 5 | Link register index |
| link_data_o | output | 32 | Return address |
| exc_o | output | 1 | Misaligned indirect target exception |
| exc_addr_o | output | 32 | Faulting target address |

## Verification
The assertions assume that `pc_i` is word aligned whenever `issue_i` is high, and they check that assumption directly. Every PC in the stimulus is a multiple of four, including the 256 MB region edge. The other register-sourced value that can be misaligned is the indirect target, and the bench drives it misaligned on purpose to reach the exception path. The bench also issues a new instruction inside the pending cycle. This exercises the rule that a control-flow instruction in a delay slot is dropped, which the single-cycle pending property relies on.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int XLEN   = 32;
  localparam int OFFW   = 16;
  localparam int IDXW   = 26;
  localparam int RIDW   = 5;
  localparam int OPW    = 4;
  localparam int LINK_R = 31;
  localparam int REGIONW = XLEN - IDXW - 2;

  typedef enum logic [OPW-1:0] {
    OP_NONE   = 4'd0,
    OP_EQ     = 4'd1,
    OP_NE     = 4'd2,
    OP_LEZ    = 4'd3,
    OP_GTZ    = 4'd4,
    OP_LTZ    = 4'd5,
    OP_GEZ    = 4'd6,
    OP_LTZ_LK = 4'd7,
    OP_GEZ_LK = 4'd8,
    OP_JABS   = 4'd9,
    OP_JABS_LK= 4'd10,
    OP_JREG   = 4'd11,
    OP_JREG_LK= 4'd12
  } bt_op_e;

  typedef enum logic [1:0] {TK_REL, TK_ABS, TK_REG, TK_NONE} bt_kind_e;

  function automatic logic [XLEN-1:0] f_rel_target(input logic [XLEN-1:0] pc,
                                                   input logic [OFFW-1:0] off);
    logic [XLEN-1:0] disp;
    disp = {{(XLEN-OFFW-2){off[OFFW-1]}}, off, 2'b00};
    return pc + XLEN'(8) + disp;
  endfunction

  function automatic logic [XLEN-1:0] f_abs_target(input logic [XLEN-1:0] pc,
                                                   input logic [IDXW-1:0] idx);
    logic [XLEN-1:0] slot;
    slot = pc + XLEN'(4);
    return {slot[XLEN-1 -: REGIONW], idx, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] f_link_value(input logic [XLEN-1:0] pc);
    return pc + XLEN'(8);
  endfunction

  function automatic bt_kind_e f_kind(input logic [OPW-1:0] op);
    case (op)
      OP_EQ, OP_NE, OP_LEZ, OP_GTZ, OP_LTZ, OP_GEZ, OP_LTZ_LK, OP_GEZ_LK: return TK_REL;
      OP_JABS, OP_JABS_LK: return TK_ABS;
      OP_JREG, OP_JREG_LK: return TK_REG;
      default: return TK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/bt_cond_eval.sv
module bt_cond_eval
  import bt_pkg::*;
(
  input  logic [OPW-1:0]  op_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic            take_o
);
  logic signed [XLEN-1:0] rs_s;
  logic rs_neg, rs_zero, ops_equal;

  assign rs_s      = $signed(rs_i);
  assign rs_neg    = rs_s < 0;
  assign rs_zero   = rs_i == '0;
  assign ops_equal = rs_i == rt_i;

  always_comb begin
    case (op_i)
      OP_EQ:                 take_o = ops_equal;
      OP_NE:                 take_o = !ops_equal;
      OP_LEZ:                take_o = rs_neg || rs_zero;
      OP_GTZ:                take_o = !rs_neg && !rs_zero;
      OP_LTZ, OP_LTZ_LK:     take_o = rs_neg;
      OP_GEZ, OP_GEZ_LK:     take_o = !rs_neg;
      OP_JABS, OP_JABS_LK,
      OP_JREG, OP_JREG_LK:   take_o = 1'b1;
      default:               take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bt_target_sel.sv
module bt_target_sel
  import bt_pkg::*;
(
  input  logic [OPW-1:0]  op_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [XLEN-1:0] rs_i,
  output logic            is_cf_o,
  output logic [XLEN-1:0] target_o,
  output logic            misalign_o
);
  bt_kind_e kind;
  logic [XLEN-1:0] rel_t, abs_t;

  assign kind  = f_kind(op_i);
  assign rel_t = f_rel_target(pc_i, off_i);
  assign abs_t = f_abs_target(pc_i, idx_i);

  always_comb begin
    is_cf_o    = 1'b1;
    misalign_o = 1'b0;
    case (kind)
      TK_REL: target_o = rel_t;
      TK_ABS: target_o = abs_t;
      TK_REG: begin
        target_o   = rs_i;
        misalign_o = rs_i[1:0] != 2'b00;
      end
      default: begin
        target_o = '0;
        is_cf_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bt_link_gen.sv
module bt_link_gen
  import bt_pkg::*;
(
  input  logic [OPW-1:0]  op_i,
  input  logic [RIDW-1:0] rd_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            we_o,
  output logic [RIDW-1:0] reg_o,
  output logic [XLEN-1:0] data_o
);
  assign data_o = f_link_value(pc_i);

  always_comb begin
    case (op_i)
      OP_LTZ_LK, OP_GEZ_LK, OP_JABS_LK: begin
        we_o  = 1'b1;
        reg_o = RIDW'(LINK_R);
      end
      OP_JREG_LK: begin
        we_o  = rd_i != '0;
        reg_o = rd_i;
      end
      default: begin
        we_o  = 1'b0;
        reg_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/bt_unit.sv
module bt_unit
  import bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [OPW-1:0]   op_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFFW-1:0]  off_i,
  input  logic [IDXW-1:0]  idx_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  input  logic [RIDW-1:0]  rd_i,
  output logic             pend_o,
  output logic             redir_o,
  output logic [XLEN-1:0]  redir_pc_o,
  output logic             link_we_o,
  output logic [RIDW-1:0]  link_reg_o,
  output logic [XLEN-1:0]  link_data_o,
  output logic             exc_o,
  output logic [XLEN-1:0]  exc_addr_o
);
  logic            take_w, is_cf_w, misalign_w, lk_we_w;
  logic [XLEN-1:0] target_w, lk_data_w;
  logic [RIDW-1:0] lk_reg_w;
  logic            accept_w, redirect_w, fault_w;

  logic            pend_q, redir_q, link_we_q, exc_arm_q, exc_q;
  logic [XLEN-1:0] redir_pc_q, link_data_q, exc_addr_q;
  logic [RIDW-1:0] link_reg_q;

  bt_cond_eval u_cond (
    .op_i(op_i), .rs_i(rs_val_i), .rt_i(rt_val_i), .take_o(take_w));

  bt_target_sel u_tgt (
    .op_i(op_i), .pc_i(pc_i), .off_i(off_i), .idx_i(idx_i), .rs_i(rs_val_i),
    .is_cf_o(is_cf_w), .target_o(target_w), .misalign_o(misalign_w));

  bt_link_gen u_link (
    .op_i(op_i), .rd_i(rd_i), .pc_i(pc_i),
    .we_o(lk_we_w), .reg_o(lk_reg_w), .data_o(lk_data_w));

  // Issue is dropped while a delay slot is being fetched (R8)
  assign accept_w   = issue_i && is_cf_w && !pend_q;
  assign redirect_w = accept_w && take_w && !misalign_w;
  assign fault_w    = accept_w && take_w && misalign_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      redir_q     <= 1'b0;
      redir_pc_q  <= '0;
      link_we_q   <= 1'b0;
      link_reg_q  <= '0;
      link_data_q <= '0;
      exc_arm_q   <= 1'b0;
      exc_q       <= 1'b0;
      exc_addr_q  <= '0;
    end else begin
      pend_q    <= accept_w;
      redir_q   <= redirect_w;
      link_we_q <= accept_w && lk_we_w;
      exc_arm_q <= fault_w;
      exc_q     <= exc_arm_q;
      if (accept_w) begin
        redir_pc_q  <= target_w;
        link_reg_q  <= lk_reg_w;
        link_data_q <= lk_data_w;
      end
      if (fault_w) exc_addr_q <= target_w;
    end
  end

  assign pend_o      = pend_q;
  assign redir_o     = redir_q;
  assign redir_pc_o  = redir_pc_q;
  assign link_we_o   = link_we_q;
  assign link_reg_o  = link_reg_q;
  assign link_data_o = link_data_q;
  assign exc_o       = exc_q;
  assign exc_addr_o  = exc_addr_q;

  // Input assumption: instruction addresses are word aligned (R10)
  a_r10_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> pc_i[1:0] == 2'b00);

  a_r7_pend_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> pend_o);

  a_r7_pend_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |=> !pend_o);

  a_r7_outputs_in_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_o || link_we_o) |-> pend_o);

  a_r10_target_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    redir_o |-> redir_pc_o[1:0] == 2'b00);

  a_r4_exc_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> (!pend_o && $past(pend_o) && !$past(redir_o)));

  a_r4_exc_addr_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> exc_addr_o[1:0] != 2'b00);

  a_r6_no_zero_link: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> link_reg_o != '0);

  a_r8_drop_during_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && issue_i) |=> !pend_o && !redir_o && !link_we_o);
endmodule

// File: tb/tb_bt_unit.sv
module tb_bt_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] pc_i = '0, rs_val_i = '0, rt_val_i = '0;
  logic [15:0] off_i = '0;
  logic [25:0] idx_i = '0;
  logic [4:0]  rd_i = '0;
  logic pend_o, redir_o, link_we_o, exc_o;
  logic [31:0] redir_pc_o, link_data_o, exc_addr_o;
  logic [4:0]  link_reg_o;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  bt_unit dut (.*);

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] pc;
    logic [15:0] off;
    logic [25:0] idx;
    logic [31:0] rs;
    logic [31:0] rt;
    logic        redir;
    logic [31:0] tgt;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{4'd1,  32'h0000_1000, 16'h0004, 26'h0, 32'd5,          32'd5,          1'b1, 32'h0000_1018},
    '{4'd1,  32'h0000_1000, 16'h0004, 26'h0, 32'd5,          32'd6,          1'b0, 32'h0},
    '{4'd2,  32'h0000_2000, 16'hFFFF, 26'h0, 32'd1,          32'd2,          1'b1, 32'h0000_2004},
    '{4'd3,  32'h0000_0100, 16'h0010, 26'h0, 32'd0,          32'd0,          1'b1, 32'h0000_0148},
    '{4'd3,  32'h0000_0100, 16'h0010, 26'h0, 32'd1,          32'd0,          1'b0, 32'h0},
    '{4'd4,  32'h0000_0100, 16'h0010, 26'h0, 32'h8000_0000,  32'd0,          1'b0, 32'h0},
    '{4'd4,  32'h0000_0100, 16'h8000, 26'h0, 32'd1,          32'd0,          1'b1, 32'hFFFE_0108},
    '{4'd5,  32'h0000_0400, 16'h0002, 26'h0, 32'hFFFF_FFFF,  32'd0,          1'b1, 32'h0000_0410},
    '{4'd6,  32'h0000_0400, 16'h0002, 26'h0, 32'd0,          32'd0,          1'b1, 32'h0000_0410},
    '{4'd6,  32'h0000_0400, 16'h0002, 26'h0, 32'h8000_0000,  32'd0,          1'b0, 32'h0},
    '{4'd9,  32'h0FFF_FFFC, 16'h0,    26'h10, 32'd0,         32'd0,          1'b1, 32'h1000_0040},
    '{4'd9,  32'h4000_0000, 16'h0,    26'h3FF_FFFF, 32'd0,   32'd0,          1'b1, 32'h4FFF_FFFC},
    '{4'd11, 32'h0000_3000, 16'h0,    26'h0, 32'h0000_8000,  32'd0,          1'b1, 32'h0000_8000},
    '{4'd1,  32'h0000_0000, 16'h0001, 26'h0, 32'h8000_0000,  32'h8000_0000,  1'b1, 32'h0000_000C},
    '{4'd7,  32'h0000_0500, 16'h0001, 26'h0, 32'd5,          32'd0,          1'b0, 32'h0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one issue; returns at the negedge inside the pending cycle
  task automatic issue(input logic [3:0] op, input logic [31:0] pc,
                       input logic [15:0] off, input logic [25:0] idx,
                       input logic [31:0] rs, input logic [31:0] rt,
                       input logic [4:0] rd);
    @(negedge clk);
    issue_i = 1'b1; op_i = op; pc_i = pc; off_i = off; idx_i = idx;
    rs_val_i = rs; rt_val_i = rt; rd_i = rd;
    @(negedge clk);
    issue_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "pend", {31'b0, pend_o}, 32'd0);
    chk("R9", "redir", {31'b0, redir_o}, 32'd0);
    chk("R9", "link_we", {31'b0, link_we_o}, 32'd0);
    chk("R9", "exc", {31'b0, exc_o}, 32'd0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R7 R10: vector table
    for (int i = 0; i < NV; i++) begin
      issue(VT[i].op, VT[i].pc, VT[i].off, VT[i].idx, VT[i].rs, VT[i].rt, 5'd0);
      chk("R7", "pend", {31'b0, pend_o}, 32'd1);
      chk("R1", "redir", {31'b0, redir_o}, {31'b0, VT[i].redir});
      if (VT[i].redir) begin
        chk("R2/R3", "target", redir_pc_o, VT[i].tgt);
        chk("R10", "target low bits", {30'b0, redir_pc_o[1:0]}, 32'd0);
      end
      @(negedge clk);
      chk("R7", "pend drop", {31'b0, pend_o}, 32'd0);
    end

    // R5: conditional link not taken still links
    issue(4'd7, 32'h0000_0500, 16'h0001, 26'h0, 32'd5, 32'd0, 5'd0);
    chk("R5", "link_we", {31'b0, link_we_o}, 32'd1);
    chk("R5", "link_reg", {27'b0, link_reg_o}, 32'd31);
    chk("R5", "link_data", link_data_o, 32'h0000_0508);
    // R5: jump-and-link absolute
    issue(4'd10, 32'h2000_0010, 16'h0, 26'h100, 32'd0, 32'd0, 5'd3);
    chk("R5", "jal redir", {31'b0, redir_o}, 32'd1);
    chk("R3", "jal target", redir_pc_o, 32'h2000_0400);
    chk("R5", "jal reg", {27'b0, link_reg_o}, 32'd31);
    chk("R5", "jal data", link_data_o, 32'h2000_0018);
    // R6: register link to rd 7
    issue(4'd12, 32'h0000_7000, 16'h0, 26'h0, 32'h0000_9000, 32'd0, 5'd7);
    chk("R6", "jalr we", {31'b0, link_we_o}, 32'd1);
    chk("R6", "jalr reg", {27'b0, link_reg_o}, 32'd7);
    chk("R6", "jalr data", link_data_o, 32'h0000_7008);
    chk("R4", "jalr target", redir_pc_o, 32'h0000_9000);
    // R6: rd 0 gives no write but redirects
    issue(4'd12, 32'h0000_7000, 16'h0, 26'h0, 32'h0000_9000, 32'd0, 5'd0);
    chk("R6", "rd0 we", {31'b0, link_we_o}, 32'd0);
    chk("R6", "rd0 redir", {31'b0, redir_o}, 32'd1);

    // R4: misaligned indirect target
    issue(4'd11, 32'h0000_3000, 16'h0, 26'h0, 32'h0000_8002, 32'd0, 5'd0);
    chk("R4", "no redirect", {31'b0, redir_o}, 32'd0);
    chk("R4", "exc during slot", {31'b0, exc_o}, 32'd0);
    @(negedge clk);
    chk("R4", "exc after slot", {31'b0, exc_o}, 32'd1);
    chk("R4", "exc addr", exc_addr_o, 32'h0000_8002);
    @(negedge clk);
    chk("R4", "exc single", {31'b0, exc_o}, 32'd0);

    // R8: issue inside the pending cycle is dropped
    issue(4'd1, 32'h0000_1000, 16'h0004, 26'h0, 32'd5, 32'd5, 5'd0);
    issue_i = 1'b1; op_i = 4'd10; pc_i = 32'h0000_1004; idx_i = 26'h40;
    @(negedge clk);
    issue_i = 1'b0;
    chk("R8", "slot issue pend", {31'b0, pend_o}, 32'd0);
    chk("R8", "slot issue redir", {31'b0, redir_o}, 32'd0);
    chk("R8", "slot issue link", {31'b0, link_we_o}, 32'd0);
    // R8: non-control codes ignored
    issue(4'd0, 32'h0000_1000, 16'h0004, 26'h0, 32'd5, 32'd5, 5'd0);
    chk("R8", "code0 pend", {31'b0, pend_o}, 32'd0);
    issue(4'd14, 32'h0000_1000, 16'h0004, 26'h0, 32'd5, 32'd5, 5'd9);
    chk("R8", "code14 pend", {31'b0, pend_o}, 32'd0);
    chk("R8", "code14 link", {31'b0, link_we_o}, 32'd0);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule